// File: doc/BRIEF.md
# Power-Down Sequencer

This block orders the steps that take a clock generator into its low-power state and back out. The request arrives on an asynchronous active-low pin. The block first resynchronizes it to an always-on low-rate timebase. On entry it drives a force signal that pins every clock output low. It keeps the oscillator and PLL running for a fixed hold window with the outputs already low. Only after that window does it remove their enables. On exit it turns the oscillator and PLL back on and keeps the outputs forced low for a programmable stabilization count. It then releases the outputs and raises a status flag that marks them as valid.

While the outputs are not valid, the two clock-stop requests (CPU group and PCI group) have no effect on their gated outputs. Entry takes a few timebase cycles. Exit takes the synchronizer delay plus the full stabilization count. Pick that count so the wait stays under 3 ms at the timebase rate; for example, 64 cycles of a 32.768 kHz timebase is about 1.95 ms.

Top module: `pd_sequencer`

## Requirements
- R1: After reset, osc_en and pll_en are 1, force_low is 0, clk_valid is 1, and each stop output follows its request.
- R2: The pd_n pin passes through SYNC_STAGES flip-flops. When pd_n is low from just before rising edge 1 while running, force_low rises and clk_valid falls on rising edge SYNC_STAGES+1.
- R3: After force_low rises, osc_en and pll_en stay 1 for exactly HOLD_CYCLES rising edges and then fall together, with force_low still 1.
- R4: While the oscillator is off, osc_en and pll_en stay 0 and force_low stays 1 for as long as pd_n is held low.
- R5: When pd_n returns high just before rising edge 1, osc_en and pll_en rise on edge SYNC_STAGES+1. force_low stays 1 and clk_valid stays 0 until edge SYNC_STAGES+1+STAB_CYCLES, where both change.
- R6: A release seen during the hold window moves straight to the stabilization wait. If the release reaches the state logic on or before the last hold edge, the oscillator is never switched off, because release takes priority over the end of the hold.
- R7: A new request during the stabilization wait does not cut the wait short. When the wait ends, the block enters the forced-low hold directly, so clk_valid never goes high.
- R8: cpu_stop_eff equals cpu_stop_req and pci_stop_eff equals pci_stop_req only while clk_valid is 1. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-rate timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_req | input | 1 | Synchronized CPU clock-stop request, active high |
| pci_stop_req | input | 1 | Synchronized PCI clock-stop request, active high |
| force_low | output | 1 | Drives all clock outputs low when 1 |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_valid | output | 1 | Status: clock outputs are valid |
| cpu_stop_eff | output | 1 | CPU stop request after power-down gating |
| pci_stop_eff | output | 1 | PCI stop request after power-down gating |

## Verification
The hardest case to reach is a release that lands inside the short hold window. Whether the oscillator is switched off then depends on exactly when the synchronized release meets the end of the hold. The stimulus sweeps the release point one timebase cycle at a time across the whole window and past it. For each offset the bench computes, from the synchronizer depth and the hold length, whether and for how long osc_en should drop. A second run re-asserts the request partway through the stabilization wait, to show that the status flag never pulses.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_FORCE_LOW = 2'd1,
    ST_OSC_OFF   = 2'd2,
    ST_WAKE_WAIT = 2'd3
  } pd_state_t;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
  parameter int HOLD_CYCLES = 4,
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic hold_done,
  output logic stab_done
);
  localparam int MAX_CNT = (HOLD_CYCLES > STAB_CYCLES) ? HOLD_CYCLES : STAB_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt <= '0;
    else if (restart)                    cnt <= '0;
    else if (cnt != CNT_W'(MAX_CNT))     cnt <= cnt + 1'b1;

  assign hold_done = (cnt == CNT_W'(HOLD_CYCLES - 1));
  assign stab_done = (cnt == CNT_W'(STAB_CYCLES - 1));
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_req,
  input  logic      hold_done,
  input  logic      stab_done,
  output pd_state_t state,
  output logic      restart
);
  pd_state_t state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_RUN:       if (pd_req) state_nxt = ST_FORCE_LOW;
      ST_FORCE_LOW: if (!pd_req)        state_nxt = ST_WAKE_WAIT;
                    else if (hold_done) state_nxt = ST_OSC_OFF;
      ST_OSC_OFF:   if (!pd_req) state_nxt = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (stab_done) state_nxt = pd_req ? ST_FORCE_LOW : ST_RUN;
      default:      state_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nxt;

  assign restart = (state_nxt != state);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic cpu_stop_req,
  input  logic pci_stop_req,
  output logic force_low,
  output logic osc_en,
  output logic pll_en,
  output logic clk_valid,
  output logic cpu_stop_eff,
  output logic pci_stop_eff
);
  logic      pd_n_s;
  logic      hold_done, stab_done, restart;
  pd_state_t state;

  pd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pd_n), .q(pd_n_s)
  );

  pd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(~pd_n_s),
    .hold_done(hold_done), .stab_done(stab_done),
    .state(state), .restart(restart)
  );

  pd_timer #(.HOLD_CYCLES(HOLD_CYCLES), .STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .hold_done(hold_done), .stab_done(stab_done)
  );

  assign clk_valid    = (state == ST_RUN);
  assign force_low    = (state != ST_RUN);
  assign osc_en       = (state != ST_OSC_OFF);
  assign pll_en       = (state != ST_OSC_OFF);
  assign cpu_stop_eff = clk_valid & cpu_stop_req;
  assign pci_stop_eff = clk_valid & pci_stop_req;
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int STAB_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic pd_n,
  input logic force_low,
  input logic osc_en,
  input logic pll_en,
  input logic clk_valid,
  input logic cpu_stop_eff,
  input logic pci_stop_eff
);
  localparam int LIM = HOLD_CYCLES + STAB_CYCLES + SYNC_STAGES + 2;
  localparam int W   = $clog2(LIM + 1);

  logic [W-1:0] pd_low_run, fl_on_run, osc_on_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_low_run <= '0;
      fl_on_run  <= '0;
      osc_on_run <= W'(LIM);
    end else begin
      pd_low_run <= pd_n ? '0 : ((pd_low_run == W'(LIM)) ? pd_low_run : pd_low_run + 1'b1);
      fl_on_run  <= !(force_low && osc_en) ? '0 :
                    ((fl_on_run == W'(LIM)) ? fl_on_run : fl_on_run + 1'b1);
      osc_on_run <= !osc_en ? '0 : ((osc_on_run == W'(LIM)) ? osc_on_run : osc_on_run + 1'b1);
    end

  AST_ENTRY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_low_run == W'(SYNC_STAGES + 1) && $past(clk_valid)) |-> force_low); // R2
  AST_HELD_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> ($past(force_low) && fl_on_run >= W'(HOLD_CYCLES))); // R3
  AST_OFF_IMPLIES_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en || !pll_en) |-> force_low); // R4
  AST_STAB_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> osc_on_run >= W'(STAB_CYCLES)); // R5
  AST_STOPS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_valid |-> (!cpu_stop_eff && !pci_stop_eff)); // R8
endmodule

bind pd_sequencer pd_sequencer_chk #(
  .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES), .STAB_CYCLES(STAB_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .force_low(force_low),
  .osc_en(osc_en), .pll_en(pll_en), .clk_valid(clk_valid),
  .cpu_stop_eff(cpu_stop_eff), .pci_stop_eff(pci_stop_eff)
);

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;
  localparam int SYNC = 2;
  localparam int HOLD = 4;
  localparam int STAB = 10;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic cpu_stop_req = 1'b0;
  logic pci_stop_req = 1'b0;
  logic force_low, osc_en, pll_en, clk_valid, cpu_stop_eff, pci_stop_eff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd_sequencer #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .cpu_stop_req(cpu_stop_req), .pci_stop_req(pci_stop_req),
    .force_low(force_low), .osc_en(osc_en), .pll_en(pll_en),
    .clk_valid(clk_valid), .cpu_stop_eff(cpu_stop_eff), .pci_stop_eff(pci_stop_eff)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string req, input logic fl, input logic osc, input logic vld);
    chk(req, "force_low", force_low, fl);
    chk(req, "osc_en", osc_en, osc);
    chk(req, "pll_en", pll_en, osc);
    chk(req, "clk_valid", clk_valid, vld);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_all("R1", 1'b0, 1'b1, 1'b1);
    cpu_stop_req = 1'b1; pci_stop_req = 1'b0; #1;
    chk("R1", "cpu_stop_eff", cpu_stop_eff, 1'b1);
    chk("R8", "pci_stop_eff", pci_stop_eff, 1'b0);
    cpu_stop_req = 1'b0; pci_stop_req = 1'b1; #1;
    chk("R8", "cpu_stop_eff", cpu_stop_eff, 1'b0);
    chk("R8", "pci_stop_eff", pci_stop_eff, 1'b1);
    pci_stop_req = 1'b0;
    @(negedge clk);

    // R2/R3/R4 entry sweep, stop requests asserted throughout
    pd_n = 1'b0;
    cpu_stop_req = 1'b1; pci_stop_req = 1'b1;
    for (int k = 1; k <= LAT + HOLD + 4; k++) begin
      tick();
      chk_all((k <= LAT + HOLD) ? ((k <= LAT) ? "R2" : "R3") : "R4",
              k >= LAT, k < LAT + HOLD, k < LAT);
      chk("R8", "cpu_stop_eff", cpu_stop_eff, (k < LAT) ? 1'b1 : 1'b0);
      chk("R8", "pci_stop_eff", pci_stop_eff, (k < LAT) ? 1'b1 : 1'b0);
    end
    cpu_stop_req = 1'b0; pci_stop_req = 1'b0;

    // R5 exit sweep from oscillator-off state
    pd_n = 1'b1;
    for (int k = 1; k <= LAT + STAB + 2; k++) begin
      tick();
      chk_all("R5", k < LAT + STAB, k >= LAT, k >= LAT + STAB);
    end

    // R6 release at every offset within and past the hold window
    for (int j = 0; j <= HOLD + 1; j++) begin
      pd_n = 1'b0;
      repeat (LAT) tick();
      chk_all("R6", 1'b1, 1'b1, 1'b0);
      for (int t = 1; t <= j; t++) begin
        tick();
        chk_all("R6", 1'b1, t < HOLD, 1'b0);
      end
      pd_n = 1'b1;
      for (int t = j + 1; t <= j + LAT + STAB + 2; t++) begin
        tick();
        chk_all("R6", t < j + LAT + STAB,
                !(t >= HOLD && t < j + LAT), t >= j + LAT + STAB);
      end
    end

    // R7 new request during stabilization wait
    pd_n = 1'b0;
    repeat (LAT + HOLD + 2) tick();
    chk_all("R7", 1'b1, 1'b0, 1'b0);
    pd_n = 1'b1;
    for (int k = 1; k <= LAT + STAB + HOLD + 3; k++) begin
      tick();
      if (k == 5) pd_n = 1'b0;
      chk_all("R7", 1'b1,
              (k >= LAT) && (k < LAT + STAB + HOLD), 1'b0);
    end
    pd_n = 1'b1;
    repeat (LAT + STAB + 1) tick();
    chk_all("R7", 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule